// File: doc/BRIEF.md
# Redundant Upstream Port Failover Controller

This block picks which of two redundant upstream ports of a switch carries the link to the root complex. It drives the select line of the multiplexer that sits in front of the two ports' SERDES, and it moves traffic to the standby port without a fundamental reset. The two candidates are port 0 and port 2. Internally, port 0 is encoded as 0 and port 2 is encoded as 1. Redundancy and the port that starts out active are both taken from a 4-bit mode strap, which is sampled while the fundamental reset is held.

Three independent sources can request a switchover:

- a write to the control register,
- a level change on the upstream select pin, after that pin has been synchronized,
- expiry of a watchdog count that software is supposed to keep reloading.

Every request passes through the same sequence:

1. The multiplexer flips.
2. A hot reset runs for a fixed number of cycles.
3. The controller waits until the new port reports that link training is done.
4. That port becomes the active one.

A control bit can restrict the hot reset to the upstream side, so the downstream ports and the core keep their state. After a switchover finishes, the controller accepts another request and can fail back to the other port.

Top module: `upstream_failover_ctl`

## Requirements
- R1: While reset is held, the controller samples `modeStrap`. Redundancy is enabled only for the values 0x8, 0x9, 0xA and 0xB. When redundancy is enabled, strap bit 0 selects the initial active port and `muxSel` follows it (0 = port 0, 1 = port 2). With any other strap value, `muxSel` is 0.
- R2: When redundancy is disabled, `muxSel` stays 0, no failover sequence starts, and `statusWord[3]` stays 0, whatever trigger arrives.
- R3: A write to the control register (`regAddr`=0) whose bit 0 differs from the active port starts a failover. A write whose bit 0 equals the active port does not start one.
- R4: A pin failover starts only when control bit 1 (pin enable) is set and the synchronized level of `portSelPin` changes to a value that differs from the active port. The trigger takes effect on the third rising edge after the pin changes.
- R5: Control bit 2 enables the watchdog. A write to the timer register (`regAddr`=1) loads the count and clears the prescaler. The count decrements once every `PRESCALE` cycles. When the count steps from 1 to 0, a failover starts and bit 2 clears by itself. If the count is reloaded before it reaches zero, no failover occurs.
- R6: The sequence runs as follows, counted from the trigger edge:
  - Busy (`statusWord[3]`) is set after the trigger edge.
  - `muxSel` flips one edge later.
  - `usHotReset` is high for exactly `HR_CYCLES` cycles.
  - The controller then waits for `linkUp`.
  - On the edge where `linkUp` is seen, busy clears and the active port (`statusWord[2]`) takes the new value.
- R7: When control bit 3 is clear, `dsHotReset` goes high together with `usHotReset`. When bit 3 is set, `dsHotReset` stays low for the whole sequence.
- R8: While a failover is in progress, any further trigger is dropped. It is neither acted on nor queued.
- R9: After a failover completes, a new trigger performs a further failover back to the other port.
- R10: The status word has the following fields:

  | Bit | Meaning |
  |-----|---------|
  | 0 | Redundancy enabled |
  | 1 | Dynamic failover enabled |
  | 2 | Active port |
  | 3 | Busy |
  | 4 | Pin enable |
  | 5 | Watchdog enable |
  | 6 | Keep-downstream |
  | 7 | Always 0 |

  Bits 0 and 1 are both set whenever redundancy is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low, synchronous |
| modeStrap | input | 4 | Boot mode strap, sampled during reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = control register, 1 = watchdog count |
| regWrData | input | WDOG_W | Write data |
| portSelPin | input | 1 | Upstream select pin, asynchronous (0 = port 0, 1 = port 2) |
| linkUp | input | 1 | Link training done on the newly selected port |
| muxSel | output | 1 | SERDES multiplexer select (0 = port 0, 1 = port 2) |
| usHotReset | output | 1 | Hot reset request to the upstream port |
| dsHotReset | output | 1 | Hot reset request to the downstream ports and core |
| statusWord | output | 8 | Status fields as listed in R10 |

## Verification
Each trigger has a fixed start delay:

- A register write sets busy right after the edge that captures it.
- A pin change sets busy after the third edge, because of the two synchronizer flops and the edge-detect flop.
- A watchdog load of N fires on the edge N×PRESCALE cycles after the load.

From that trigger edge, the multiplexer flips one edge later, the hot reset covers the next HR_CYCLES edges, and completion comes on the edge that samples `linkUp`. The bench drives and samples on falling edges and counts exactly that many of them before each check. Values are also checked one cycle before each event, so an early transition fails as well as a late one.

// File: rtl/ufo_pkg.sv
package ufo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWITCH_MUX,
    ST_HOT_RESET,
    ST_WAIT_LINKUP
  } foState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic flipMux;  // toggle the SERDES select this cycle
    logic commit;   // new port trained, make it the active one
    logic idle;     // no failover in progress
  } foStrobe_t;

  localparam logic ADDR_CTRL  = 1'b0;
  localparam logic ADDR_TIMER = 1'b1;

  // control register bit positions
  localparam int CB_PORT   = 0;
  localparam int CB_PIN_EN = 1;
  localparam int CB_TMR_EN = 2;
  localparam int CB_KEEP   = 3;

endpackage

// File: rtl/ufo_datapath.sv
module ufo_datapath
  import ufo_pkg::*;
#(
  parameter int WDOG_W   = 16,
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        modeStrap,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WDOG_W-1:0] regWrData,
  input  logic              portSelPin,
  input  foStrobe_t         strb,
  output logic              trig,
  output logic              muxSel,
  output logic              keepDs,
  output logic [7:0]        statusWord
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic redEn, activePort, pinEn, timerEn;
  logic pinSync1, pinSync2, pinPrev;
  logic [PRE_W-1:0]  presc;
  logic [WDOG_W-1:0] wdCount;
  logic ctrlWr, timerWr, tick, swTrig, pinTrig, timerFire;
  logic strapRed;

  assign strapRed  = (modeStrap >= 4'h8) && (modeStrap <= 4'hB);
  assign ctrlWr    = regWrEn && (regAddr == ADDR_CTRL);
  assign timerWr   = regWrEn && (regAddr == ADDR_TIMER);
  assign tick      = (presc == PRE_LAST);
  assign swTrig    = ctrlWr && (regWrData[CB_PORT] != activePort);
  assign pinTrig   = pinEn && (pinSync2 != pinPrev) && (pinSync2 != activePort);
  assign timerFire = timerEn && !timerWr && tick && (wdCount == WDOG_W'(1));
  assign trig      = redEn && strb.idle && (swTrig || pinTrig || timerFire);

  // strap capture, port selection and the active port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redEn      <= strapRed;
      muxSel     <= strapRed & modeStrap[0];
      activePort <= strapRed & modeStrap[0];
    end else begin
      if (strb.flipMux) muxSel <= ~muxSel;
      if (strb.commit)  activePort <= muxSel;
    end
  end

  // control fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinEn   <= 1'b0;
      timerEn <= 1'b0;
      keepDs  <= 1'b0;
    end else if (ctrlWr) begin
      pinEn   <= regWrData[CB_PIN_EN];
      timerEn <= regWrData[CB_TMR_EN];
      keepDs  <= regWrData[CB_KEEP];
    end else if (timerFire) begin
      timerEn <= 1'b0;
    end
  end

  // select pin synchronizer and edge memory
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinSync1 <= 1'b0;
      pinSync2 <= 1'b0;
      pinPrev  <= 1'b0;
    end else begin
      pinSync1 <= portSelPin;
      pinSync2 <= pinSync1;
      pinPrev  <= pinSync2;
    end
  end

  // watchdog prescaler and count
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc   <= '0;
      wdCount <= '0;
    end else if (timerWr) begin
      presc   <= '0;
      wdCount <= regWrData;
    end else if (timerEn) begin
      presc <= tick ? '0 : presc + 1'b1;
      if (tick && wdCount != '0) wdCount <= wdCount - 1'b1;
    end else begin
      presc <= '0;
    end
  end

  assign statusWord = {1'b0, keepDs, timerEn, pinEn, ~strb.idle,
                       activePort, redEn, redEn};

  AST_IDLE_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    strb.idle |-> (activePort == muxSel));  // R6
  AST_FIXED_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    !redEn |-> !muxSel);  // R2
  AST_TIMER_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    timerFire |=> !timerEn);  // R5

endmodule

// File: rtl/ufo_control.sv
module ufo_control
  import ufo_pkg::*;
#(
  parameter int HR_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trig,
  input  logic      linkUp,
  input  logic      keepDs,
  output foStrobe_t strb,
  output logic      usHotReset,
  output logic      dsHotReset
);

  localparam int HR_W = (HR_CYCLES > 1) ? $clog2(HR_CYCLES) : 1;
  localparam logic [HR_W-1:0] HR_LAST = HR_W'(HR_CYCLES - 1);

  foState_t state;
  logic [HR_W-1:0] hrCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hrCnt <= '0;
    end else begin
      case (state)
        ST_IDLE:       if (trig) state <= ST_SWITCH_MUX;
        ST_SWITCH_MUX: begin
          state <= ST_HOT_RESET;
          hrCnt <= '0;
        end
        ST_HOT_RESET: begin
          if (hrCnt == HR_LAST) state <= ST_WAIT_LINKUP;
          else hrCnt <= hrCnt + 1'b1;
        end
        ST_WAIT_LINKUP: if (linkUp) state <= ST_IDLE;
        default:        state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.flipMux = (state == ST_SWITCH_MUX);
    strb.commit  = (state == ST_WAIT_LINKUP) && linkUp;
    strb.idle    = (state == ST_IDLE);
  end

  assign usHotReset = (state == ST_HOT_RESET);
  assign dsHotReset = (state == ST_HOT_RESET) && !keepDs;

  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_SWITCH_MUX));  // R8
  AST_LINK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LINKUP && linkUp) |=> (state == ST_IDLE));  // R6
  AST_HR_ENDS_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usHotReset) |-> (state == ST_WAIT_LINKUP));  // R6
  AST_HR_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usHotReset) |-> ($past(state) == ST_SWITCH_MUX));  // R6

endmodule

// File: rtl/upstream_failover_ctl.sv
module upstream_failover_ctl
  import ufo_pkg::*;
#(
  parameter int WDOG_W    = 16,
  parameter int PRESCALE  = 8,
  parameter int HR_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        modeStrap,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WDOG_W-1:0] regWrData,
  input  logic              portSelPin,
  input  logic              linkUp,
  output logic              muxSel,
  output logic              usHotReset,
  output logic              dsHotReset,
  output logic [7:0]        statusWord
);

  foStrobe_t strb;
  logic trig, keepDs;

  ufo_datapath #(.WDOG_W(WDOG_W), .PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rst_n(rst_n), .modeStrap(modeStrap),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .portSelPin(portSelPin), .strb(strb), .trig(trig),
    .muxSel(muxSel), .keepDs(keepDs), .statusWord(statusWord)
  );

  ufo_control #(.HR_CYCLES(HR_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .linkUp(linkUp),
    .keepDs(keepDs), .strb(strb),
    .usHotReset(usHotReset), .dsHotReset(dsHotReset)
  );

endmodule

// File: tb/sim_upstream_failover_ctl.sv
`timescale 1ns/1ps
module sim_upstream_failover_ctl;

  localparam int WDOG_W = 16;
  localparam int PRESCALE = 8;
  localparam int HR_CYCLES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] modeStrap = 4'h8;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [WDOG_W-1:0] regWrData = '0;
  logic portSelPin = 1'b0;
  logic linkUp = 1'b0;
  logic muxSel, usHotReset, dsHotReset;
  logic [7:0] statusWord;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  upstream_failover_ctl #(.WDOG_W(WDOG_W), .PRESCALE(PRESCALE), .HR_CYCLES(HR_CYCLES)) u0 (
    .clk(clk), .rst_n(rst_n), .modeStrap(modeStrap), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .portSelPin(portSelPin),
    .linkUp(linkUp), .muxSel(muxSel), .usHotReset(usHotReset),
    .dsHotReset(dsHotReset), .statusWord(statusWord)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [3:0] strap);
    rst_n = 1'b0;
    modeStrap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic addr, input logic [WDOG_W-1:0] data);
    regWrEn = 1'b1;
    regAddr = addr;
    regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Called at the falling edge right after the trigger edge.
  task automatic runSequence(input bit keep, input bit newPort, input bit inject);
    chk(statusWord[3] == 1'b1, "R6 busy after trigger", statusWord[3], 1);
    chk(muxSel == !newPort, "R6 mux not yet flipped", muxSel, !newPort);
    if (inject) regWrite(1'b0, WDOG_W'(!newPort ? 1 : 0) ^ WDOG_W'(1)); // R8 differs from active
    else @(negedge clk);
    chk(muxSel == newPort, "R6 mux flipped", muxSel, newPort);
    chk(usHotReset == 1'b1, "R6 upstream hot reset", usHotReset, 1);
    chk(dsHotReset == !keep, "R7 downstream hot reset", dsHotReset, !keep);
    repeat (HR_CYCLES - 1) @(negedge clk);
    chk(usHotReset == 1'b1, "R6 hot reset last cycle", usHotReset, 1);
    @(negedge clk);
    chk(usHotReset == 1'b0 && dsHotReset == 1'b0, "R6 hot reset ended", usHotReset, 0);
    chk(statusWord[3:2] == {1'b1, !newPort}, "R6 waiting, old port active",
        statusWord[3:2], {1'b1, !newPort});
    repeat (2) @(negedge clk);
    chk(statusWord[3] == 1'b1, "R6 holds until link up", statusWord[3], 1);
    linkUp = 1'b1;
    @(negedge clk);
    linkUp = 1'b0;
    chk(statusWord[3:2] == {1'b0, newPort}, "R6 commit on link up",
        statusWord[3:2], {1'b0, newPort});
    @(negedge clk);
    chk(statusWord[3] == 1'b0, "R8 no queued trigger", statusWord[3], 0);
  endtask

  task automatic testResetRedundant();
    doReset(4'h8);
    chk(statusWord == 8'h03, "R1 R10 reset status strap 0x8", statusWord, 8'h03);
    chk(muxSel == 1'b0, "R1 initial mux port 0", muxSel, 0);
    chk(!usHotReset && !dsHotReset, "R6 no hot reset at rest", usHotReset, 0);
  endtask

  task automatic testSoftware();
    regWrite(1'b0, 16'h0001);  // R3 port field -> port 2
    runSequence(1'b0, 1'b1, 1'b0);
    regWrite(1'b0, 16'h0001);  // R3 same as active
    chk(statusWord[3] == 1'b0 && muxSel == 1'b1, "R3 same port no failover", statusWord[3], 0);
  endtask

  task automatic testPin();
    regWrite(1'b0, 16'h000B);  // pin en, keep, port 2
    chk(statusWord[6] && statusWord[4], "R10 control bits in status", statusWord[6:4], 3'b101);
    portSelPin = 1'b1;          // equals active port: no trigger
    repeat (5) @(negedge clk);
    chk(statusWord[3] == 1'b0, "R4 pin equal to active ignored", statusWord[3], 0);
    portSelPin = 1'b0;
    repeat (2) @(negedge clk);
    chk(statusWord[3] == 1'b0, "R4 not before third edge", statusWord[3], 0);
    @(negedge clk);
    runSequence(1'b1, 1'b0, 1'b0);  // R9 fail back to port 0
  endtask

  task automatic testPinDisabled();
    regWrite(1'b0, 16'h0000);
    portSelPin = 1'b1;
    repeat (6) @(negedge clk);
    chk(statusWord[3] == 1'b0 && muxSel == 1'b0, "R4 pin ignored when disabled", statusWord[3], 0);
  endtask

  task automatic testTimer();
    regWrite(1'b0, 16'h0004);  // timer en, port 0
    regWrite(1'b1, 16'd2);
    repeat (2 * PRESCALE - 1) @(negedge clk);
    chk(statusWord[3] == 1'b0 && statusWord[5], "R5 not fired early", statusWord[3], 0);
    @(negedge clk);
    chk(statusWord[5] == 1'b0, "R5 timer self disabled", statusWord[5], 0);
    runSequence(1'b0, 1'b1, 1'b1);  // R8 inject during busy, R9 repeat
    chk(statusWord[2] == 1'b1 && muxSel == 1'b1, "R8 injected write ignored", statusWord[2], 1);
  endtask

  task automatic testTimerReload();
    regWrite(1'b0, 16'h0005);  // timer en, port 2
    regWrite(1'b1, 16'd3);
    repeat (3 * PRESCALE - 3) @(negedge clk);
    regWrite(1'b1, 16'd3);
    repeat (3 * PRESCALE - 3) @(negedge clk);
    regWrite(1'b1, 16'd3);
    chk(statusWord[3] == 1'b0 && statusWord[5] && muxSel, "R5 reload prevents failover",
        statusWord[3], 0);
    regWrite(1'b0, 16'h0001);
    repeat (4 * PRESCALE) @(negedge clk);
    chk(statusWord[3] == 1'b0 && muxSel == 1'b1, "R5 disabled timer silent", statusWord[3], 0);
  endtask

  task automatic testNonRedundant();
    portSelPin = 1'b0;
    doReset(4'h3);
    chk(statusWord[1:0] == 2'b00 && muxSel == 1'b0, "R1 strap 0x3 not redundant",
        statusWord[1:0], 0);
    regWrite(1'b0, 16'h0003);  // port 2 + pin enable
    portSelPin = 1'b1;
    repeat (5) @(negedge clk);
    chk(statusWord[3] == 1'b0 && muxSel == 1'b0 && !usHotReset, "R2 triggers ignored",
        muxSel, 0);
    regWrite(1'b0, 16'h0004);
    regWrite(1'b1, 16'd1);
    repeat (PRESCALE + 2) @(negedge clk);
    chk(statusWord[3] == 1'b0 && muxSel == 1'b0, "R2 watchdog ignored", muxSel, 0);
  endtask

  task automatic testStrapPort2();
    portSelPin = 1'b0;
    doReset(4'hB);
    chk(statusWord == 8'h07 && muxSel == 1'b1, "R1 strap 0xB starts on port 2", statusWord, 8'h07);
    doReset(4'hC);
    chk(statusWord == 8'h00 && muxSel == 1'b0, "R1 strap 0xC not redundant", statusWord, 8'h00);
  endtask

  initial begin
    testResetRedundant();
    testSoftware();
    testPin();
    testPinDisabled();
    testTimer();
    testTimerReload();
    testNonRedundant();
    testStrapPort2();
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 100000) begin
      if (!done) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule